// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, given as a segment number and an offset, into a physical main-memory address. It holds a small segment table on chip. Each entry has a base address, a length, a presence flag, a modified flag and three permission flags (read, write, execute). Software fills the table through a configuration write port. Software reads the modified flag of any entry through a status port, so it knows which segments must be copied back to disk before their space is reused.

For each request the block looks up the selected entry. It then checks presence, bounds and permission, in that priority order. It returns either the physical address (base plus offset) or a single fault code. The response is registered and marked by a one-cycle valid pulse. A write that passes every check sets the entry's modified flag. Loading segments, finding free space and compaction are left to software.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low, `rsp_fault` and `rsp_paddr` are zero, every entry is marked absent and every modified flag is clear.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and is low in every other cycle.
- R3: When all checks pass, `rsp_fault` is 0 and `rsp_paddr` equals entry base plus zero-extended offset, modulo 2^PA_W.
- R4: If the selected entry is absent, `rsp_fault` is 1 (absent).
- R5: If the entry is present and the offset is greater than or equal to the entry length, `rsp_fault` is 2 (bounds). A length of 0 rejects every offset.
- R6: If the entry is present and in bounds but the access is not allowed, `rsp_fault` is 3 (rights). The access codes are 0 read, 1 write, 2 execute and 3 reserved. The rights bits are bit 0 read, bit 1 write and bit 2 execute. Code 3 is never allowed.
- R7: When more than one fault applies, only the highest one is reported. The order is absent first, then bounds, then rights.
- R8: A faulted response carries `rsp_paddr` equal to 0.
- R9: A write request that passes every check sets the modified flag of its entry. A read, an execute or a faulted write leaves the flag unchanged.
- R10: A configuration write updates the entry at the clock edge and clears its modified flag. A request in the same cycle still sees the old contents. If that request is a successful write to the same entry, the clear wins.
- R11: `sts_changed` shows, one cycle later, the modified flag of entry `sts_idx` as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_base | input | PA_W | Base address for the entry |
| cfg_len | input | OFS_W | Segment length in words |
| cfg_present | input | 1 | Presence flag for the entry |
| cfg_rights | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | IDX_W | Segment number |
| req_off | input | OFS_W | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 bounds, 3 rights |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| sts_idx | input | IDX_W | Entry whose modified flag is read |
| sts_changed | output | 1 | Registered modified flag of `sts_idx` |

## Verification
Directed requests cover the following cases:
- An offset one below and one at the length separates the bounds test from an off-by-one.
- A base near the top of the address space shows that the sum wraps.
- Entries built to fail two or three checks at once expose the fault priority.
- A configuration write in the same cycle as a write to the same entry shows which contents the request sees and which update to the modified flag wins.

A long run of mixed requests and table writes, with idle gaps, then compares every output against a behavioural table model on every clock.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_RIGHTS = 2'd3
  } flt_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEG = 16,
  parameter int IDX_W   = 4,
  parameter int PA_W    = 24,
  parameter int OFS_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFS_W-1:0] wr_len,
  input  logic             wr_present,
  input  logic [2:0]       wr_rights,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFS_W-1:0] rd_len,
  output logic             rd_present,
  output logic [2:0]       rd_rights,
  input  logic             set_chg,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] st_idx,
  output logic             st_chg
);
  // Base, length and rights: plain arrays without reset, so RAM can be inferred.
  logic [PA_W-1:0]  base_mem   [NUM_SEG];
  logic [OFS_W-1:0] len_mem    [NUM_SEG];
  logic [2:0]       rights_mem [NUM_SEG];
  // Presence and modified flags need a reset, so they stay in flops.
  logic [NUM_SEG-1:0] present_q;
  logic [NUM_SEG-1:0] chg_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx]   <= wr_base;
      len_mem[wr_idx]    <= wr_len;
      rights_mem[wr_idx] <= wr_rights;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= '0;
    end else if (wr_en) begin
      present_q[wr_idx] <= wr_present;
    end
  end

  // The configuration clear comes last, so it wins over a same-cycle set.
  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q  <= '0;
      st_chg <= 1'b0;
    end else begin
      st_chg <= chg_q[st_idx];
      if (set_chg) chg_q[set_idx] <= 1'b1;
      if (wr_en)   chg_q[wr_idx]  <= 1'b0;
    end
  end

  assign rd_base    = base_mem[rd_idx];
  assign rd_len     = len_mem[rd_idx];
  assign rd_rights  = rights_mem[rd_idx];
  assign rd_present = present_q[rd_idx];

  p_cfg_clears_chg_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !chg_q[$past(wr_idx)]);

  p_write_sets_chg_r9: assert property (@(posedge clk) disable iff (rst)
    (set_chg && !(wr_en && wr_idx == set_idx)) |=> chg_q[$past(set_idx)]);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int PA_W  = 24,
  parameter int OFS_W = 16
) (
  input  logic             present,
  input  logic [2:0]       rights,
  input  logic [OFS_W-1:0] len,
  input  logic [PA_W-1:0]  base,
  input  logic [OFS_W-1:0] off,
  input  logic [1:0]       acc,
  output flt_e             fault,
  output logic [PA_W-1:0]  paddr
);
  logic rights_ok;

  always_comb begin
    case (acc_e'(acc))
      ACC_RD:  rights_ok = rights[0];
      ACC_WR:  rights_ok = rights[1];
      ACC_EX:  rights_ok = rights[2];
      default: rights_ok = 1'b0;
    endcase
  end

  // Priority: absent first, then bounds, then rights.
  always_comb begin
    if (!present)         fault = FLT_ABSENT;
    else if (off >= len)  fault = FLT_BOUNDS;
    else if (!rights_ok)  fault = FLT_RIGHTS;
    else                  fault = FLT_NONE;
  end

  assign paddr = base + PA_W'(off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int PA_W    = 24,
  parameter int OFS_W   = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFS_W-1:0] cfg_len,
  input  logic             cfg_present,
  input  logic [2:0]       cfg_rights,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_seg,
  input  logic [OFS_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic [IDX_W-1:0] sts_idx,
  output logic             sts_changed
);
  logic [PA_W-1:0]  tbl_base;
  logic [OFS_W-1:0] tbl_len;
  logic             tbl_present;
  logic [2:0]       tbl_rights;
  flt_e             chk_fault;
  logic [PA_W-1:0]  chk_paddr;
  logic             wr_ok;

  assign wr_ok = req_valid && (acc_e'(req_acc) == ACC_WR) && (chk_fault == FLT_NONE);

  seg_table #(
    .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .PA_W(PA_W), .OFS_W(OFS_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_len(cfg_len),
    .wr_present(cfg_present), .wr_rights(cfg_rights),
    .rd_idx(req_seg), .rd_base(tbl_base), .rd_len(tbl_len),
    .rd_present(tbl_present), .rd_rights(tbl_rights),
    .set_chg(wr_ok), .set_idx(req_seg),
    .st_idx(sts_idx), .st_chg(sts_changed)
  );

  seg_check #(.PA_W(PA_W), .OFS_W(OFS_W)) u_check (
    .present(tbl_present), .rights(tbl_rights), .len(tbl_len),
    .base(tbl_base), .off(req_off), .acc(req_acc),
    .fault(chk_fault), .paddr(chk_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 2'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? chk_fault : FLT_NONE;
      rsp_paddr <= (req_valid && chk_fault == FLT_NONE) ? chk_paddr : '0;
    end
  end

  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_absent_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !tbl_present) |=> (rsp_fault == 2'd1));

  p_bounds_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && tbl_present && req_off >= tbl_len) |=> (rsp_fault == 2'd2));

  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  localparam int NUM_SEG = 16;
  localparam int IDX_W   = 4;
  localparam int PA_W    = 24;
  localparam int OFS_W   = 16;
  localparam int MASK    = (1 << PA_W) - 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we;
  logic [IDX_W-1:0] cfg_idx;
  logic [PA_W-1:0]  cfg_base;
  logic [OFS_W-1:0] cfg_len;
  logic             cfg_present;
  logic [2:0]       cfg_rights;
  logic             req_valid;
  logic [IDX_W-1:0] req_seg;
  logic [OFS_W-1:0] req_off;
  logic [1:0]       req_acc;
  logic             rsp_valid;
  logic [1:0]       rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;
  logic [IDX_W-1:0] sts_idx;
  logic             sts_changed;

  seg_xlate #(.NUM_SEG(NUM_SEG), .PA_W(PA_W), .OFS_W(OFS_W)) dut (.*);

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_base [NUM_SEG];
  int m_len  [NUM_SEG];
  int m_rt   [NUM_SEG];
  bit m_pres [NUM_SEG];
  bit m_chg  [NUM_SEG];
  int e_valid, e_fault, e_paddr, e_sts;

  function automatic int model_fault(int s, int off, int acc);
    bit ok;
    ok = (acc == 0) ? m_rt[s][0] : (acc == 1) ? m_rt[s][1] : (acc == 2) ? m_rt[s][2] : 1'b0;
    if (!m_pres[s])      return 1;
    if (off >= m_len[s]) return 2;
    if (!ok)             return 3;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NUM_SEG; i++) begin
      m_pres[i] = 0; m_chg[i] = 0; m_base[i] = 0; m_len[i] = 0; m_rt[i] = 0;
    end
    e_valid = 0; e_fault = 0; e_paddr = 0; e_sts = 0;
  endtask

  task automatic compare();
    string tag;
    if (!e_valid)          tag = "R2";
    else if (e_fault == 1) tag = "R4 R7 R8";
    else if (e_fault == 2) tag = "R5 R7 R8";
    else if (e_fault == 3) tag = "R6 R8";
    else                   tag = "R3";
    n_vec++;
    if (rsp_valid !== e_valid[0] || rsp_fault !== e_fault[1:0] || rsp_paddr !== e_paddr[PA_W-1:0]) begin
      n_bad++;
      $display("FAIL %s: valid/fault/paddr got %0d/%0d/%h expected %0d/%0d/%h",
               tag, rsp_valid, rsp_fault, rsp_paddr, e_valid, e_fault, e_paddr);
    end
    n_vec++;
    if (sts_changed !== e_sts[0]) begin
      n_bad++;
      $display("FAIL R11 R9 R10: sts_changed got %0d expected %0d", sts_changed, e_sts);
    end
  endtask

  // One clock: model the current inputs, advance to the next negedge, compare.
  task automatic tick();
    int f;
    f = model_fault(int'(req_seg), int'(req_off), int'(req_acc));
    e_valid = req_valid;
    e_fault = req_valid ? f : 0;
    e_paddr = (req_valid && f == 0) ? ((m_base[req_seg] + int'(req_off)) & MASK) : 0;
    e_sts   = m_chg[sts_idx];
    if (req_valid && req_acc == 2'd1 && f == 0) m_chg[req_seg] = 1;
    if (cfg_we) begin
      m_base[cfg_idx] = int'(cfg_base); m_len[cfg_idx] = int'(cfg_len);
      m_rt[cfg_idx] = int'(cfg_rights); m_pres[cfg_idx] = cfg_present; m_chg[cfg_idx] = 0;
    end
    @(negedge clk);
    compare();
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic set_cfg(int idx, int base, int len, bit pres, int rt);
    cfg_we = 1; cfg_idx = idx[IDX_W-1:0]; cfg_base = base[PA_W-1:0];
    cfg_len = len[OFS_W-1:0]; cfg_present = pres; cfg_rights = rt[2:0];
  endtask

  task automatic set_req(int s, int off, int acc);
    req_valid = 1; req_seg = s[IDX_W-1:0]; req_off = off[OFS_W-1:0]; req_acc = acc[1:0];
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; req_valid = 0; cfg_idx = 0; cfg_base = 0; cfg_len = 0;
    cfg_present = 0; cfg_rights = 0; req_seg = 0; req_off = 0; req_acc = 0; sts_idx = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare();                          // R1 reset state
    set_req(3, 0, 0); tick();           // R1 all entries absent -> R4
    tick();                             // R2 idle cycle

    set_cfg(2, 'h1000, 'h100, 1, 3'b011); tick();
    set_cfg(5, 'hFFFFF0, 'h40, 1, 3'b001); tick();
    set_cfg(7, 'h2000, 0, 0, 3'b000); tick();
    set_cfg(9, 'h300, 'h10, 1, 3'b100); tick();

    set_req(2, 'h10, 0); tick();        // R3 read
    set_req(2, 'hFF, 1); tick();        // R3 last word, R9 sets flag
    set_req(2, 'h100, 0); tick();       // R5 offset equals length
    set_req(2, 'h20, 2); tick();        // R6 execute not allowed
    set_req(5, 'h20, 0); tick();        // R3 base+offset wraps
    set_req(5, 'h20, 1); tick();        // R6 write to read-only, R9 no flag
    set_req(5, 'h40, 1); tick();        // R7 bounds beats rights
    set_req(7, 'h50, 1); tick();        // R7 absent beats bounds and rights
    set_req(9, 0, 2); tick();           // R3 execute allowed
    set_req(9, 5, 0); tick();           // R6 read not allowed
    set_req(9, 5, 3); tick();           // R6 reserved code
    set_req(9, 'h10, 3); tick();        // R7 bounds beats rights

    sts_idx = 2; tick(); tick();        // R11 flag of entry 2 set
    sts_idx = 5; tick(); tick();        // R11 R9 entry 5 still clear

    // R10: same-cycle config write and write request to entry 2
    set_cfg(2, 'h4000, 'h8, 1, 3'b010);
    set_req(2, 'h50, 1); tick();        // old contents apply
    sts_idx = 2; tick(); tick();        // clear wins
    set_req(2, 'h50, 1); tick();        // R10 new length applies -> R5
    set_req(2, 'h7, 1); tick();         // R10 new base
    tick();                             // R11 flag shows set

    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 7) == 0)
        set_cfg($urandom_range(0, NUM_SEG-1), $urandom, $urandom_range(0, 64),
                $urandom_range(0, 3) != 0, $urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0)
        set_req($urandom_range(0, NUM_SEG-1), $urandom_range(0, 80), $urandom_range(0, 3));
      sts_idx = 4'($urandom_range(0, NUM_SEG-1));
      tick();
    end

    rst = 1; @(negedge clk); model_reset(); rst = 0;
    compare();                          // R1 reset clears everything
    set_req(2, 0, 0); tick();           // R1 entry absent again

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule